// File: doc/BRIEF.md
# Static Rate-Matched Firing Controller with Ping-Pong Channel

This block runs a fixed, precomputed schedule for a pair of streaming filters joined by one channel. The upstream filter writes two items each time it is fired and the downstream filter reads three. The block holds the channel and a state machine that replays one steady-state period. A period has three upstream firings and two downstream firings, so six items go in and six come out. The firings follow the order up, down, up, down, up. Before it issues the next fire command, the machine waits for the done pulse of the firing in flight.

The channel has two halves of six slots each. The upstream filter fills one half while the downstream filter empties the other. The halves trade roles only at the end of a period, when the write half holds six fresh items and the read half is empty. Neither filter is ever stalled and neither side is checked for room or data: correctness comes from the schedule alone. In the first period after reset the read half holds nothing, so downstream firings are left out of that period. The `run` input starts the schedule. When `run` is dropped, the current period still runs to its end and the controller then parks.

Top module: `static_sched_ctrl`

## Requirements
- R1: After reset, and while `run` has been low since reset, `upFire` and `downFire` stay low.
- R2: Each period issues fire pulses in the order up, down, up, down, up. Every pulse lasts exactly one cycle, and the two pulses are never high together.
- R3: After a fire pulse, no further fire pulse of either kind is issued until the matching done input (`upDone` or `downDone`) has been seen high.
- R4: The first period after reset issues exactly three up firings and no down firing.
- R5: The two halves trade roles only after a period's three up firings and two down firings have all completed. At that point the write half holds six items, and the read half has been fully drained if it was in use.
- R6: The downstream filter reads every item exactly once, in the order it was written, one period after it was written. No slot is read before it is written and no slot is written before it has been read.
- R7: With `run` low, the controller finishes the current period and then issues no fire pulse. When `run` returns high it resumes with down firings included, and the six items still buffered are delivered first.
- R8: Pushes and pops are taken on every cycle they are asserted, with no back-pressure. `popData` always shows the slot at the current read position, so three pops on back-to-back cycles return three consecutive items.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start or continue the schedule; sampled at period boundaries |
| upFire | output | 1 | One-cycle command to fire the upstream filter |
| upDone | input | 1 | Upstream firing complete |
| downFire | output | 1 | One-cycle command to fire the downstream filter |
| downDone | input | 1 | Downstream firing complete |
| pushEn | input | 1 | Upstream writes `pushData` into the channel this cycle |
| pushData | input | DATA_W | Item written by the upstream filter |
| popEn | input | 1 | Downstream consumes the item at the read position this cycle |
| popData | output | DATA_W | Item at the current read position |

## Verification
The bench goes after the warm-up period. A controller that fired downstream too early would hand out slots never written, and the data check would catch the stale values. Done latencies are random, and some firings use zero latency with back-to-back pops. A machine that issued the next command without waiting, or a buffer that swapped halves mid-period, would show up as an order error or as a skipped or repeated item. Stopping mid-period and then resuming tests that the period runs to its end and that the six parked items come out first. A design that halted at once or re-entered warm-up would lose or reorder data.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_FIRE_UP, S_WAIT_UP, S_FIRE_DN, S_WAIT_DN, S_SWAP
  } sched_state_t;

  // strobes from control to the ping-pong buffer
  typedef struct packed {
    logic swapHalves;
    logic readArmed;
  } buf_stb_t;

  function automatic int gcdOf(int a, int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

endpackage

// File: rtl/sched_pingpong_buf.sv
module sched_pingpong_buf
  import sched_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ITEMS  = 6,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  buf_stb_t          stb,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  output logic [DATA_W-1:0] popData,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr
);
  localparam int SLOTS = 2 * ITEMS;
  localparam int AW    = $clog2(SLOTS);

  logic [DATA_W-1:0] mem [SLOTS];
  logic              wrHalf;
  logic [AW-1:0]     wrAddr;
  logic [AW-1:0]     rdAddr;
  logic              wrRoom;
  logic              rdLeft;

  assign wrRoom = wrPtr < PTR_W'(ITEMS);
  assign rdLeft = rdPtr < PTR_W'(ITEMS);
  assign wrAddr = wrHalf ? AW'(ITEMS) + AW'(wrPtr) : AW'(wrPtr);
  assign rdAddr = wrHalf ? AW'(rdPtr) : AW'(ITEMS) + AW'(rdPtr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrHalf <= 1'b0;
      wrPtr  <= '0;
      rdPtr  <= '0;
    end else if (stb.swapHalves) begin
      wrHalf <= ~wrHalf;
      wrPtr  <= '0;
      rdPtr  <= '0;
    end else begin
      if (pushEn && wrRoom) wrPtr <= wrPtr + 1'b1;
      if (popEn && rdLeft && stb.readArmed) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pushEn && wrRoom && !stb.swapHalves) mem[wrAddr] <= pushData;
  end

  assign popData = rdLeft ? mem[rdAddr] : '0;

endmodule

// File: rtl/sched_ctrl_fsm.sv
module sched_ctrl_fsm
  import sched_pkg::*;
#(
  parameter int UP_FIRES = 3,
  parameter int DN_FIRES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     run,
  input  logic     upDone,
  input  logic     downDone,
  output logic     upFire,
  output logic     downFire,
  output buf_stb_t stb
);
  localparam int MAXF  = (UP_FIRES > DN_FIRES) ? UP_FIRES : DN_FIRES;
  localparam int CNT_W = $clog2(MAXF + 1);

  sched_state_t state, stateNxt;
  logic [CNT_W-1:0] upCnt, dnCnt;
  logic primed;
  logic upLeft, dnLeft, pickUp, periodDone;

  assign upLeft     = upCnt < CNT_W'(UP_FIRES);
  assign dnLeft     = dnCnt < CNT_W'(DN_FIRES);
  assign periodDone = !upLeft && !dnLeft;
  // interleave: upstream goes first whenever it is not ahead of downstream
  assign pickUp     = upLeft && (!dnLeft || (upCnt <= dnCnt));

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE:    if (run) stateNxt = S_ISSUE;
      S_ISSUE: begin
        if (periodDone)  stateNxt = S_SWAP;
        else if (pickUp) stateNxt = S_FIRE_UP;
        else if (primed) stateNxt = S_FIRE_DN;
      end
      S_FIRE_UP: stateNxt = S_WAIT_UP;
      S_WAIT_UP: if (upDone) stateNxt = S_ISSUE;
      S_FIRE_DN: stateNxt = S_WAIT_DN;
      S_WAIT_DN: if (downDone) stateNxt = S_ISSUE;
      S_SWAP:    stateNxt = run ? S_ISSUE : S_IDLE;
      default:   stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      upCnt  <= '0;
      dnCnt  <= '0;
      primed <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == S_WAIT_UP && upDone) upCnt <= upCnt + 1'b1;
      if (state == S_WAIT_DN && downDone) dnCnt <= dnCnt + 1'b1;
      // warm-up: downstream slot in the period is skipped, read half is empty
      if (state == S_ISSUE && !periodDone && !pickUp && !primed)
        dnCnt <= dnCnt + 1'b1;
      if (state == S_SWAP) begin
        upCnt  <= '0;
        dnCnt  <= '0;
        primed <= 1'b1;
      end
    end
  end

  assign upFire         = state == S_FIRE_UP;
  assign downFire       = state == S_FIRE_DN;
  assign stb.swapHalves = state == S_SWAP;
  assign stb.readArmed  = primed;

endmodule

// File: rtl/static_sched_ctrl.sv
module static_sched_ctrl
  import sched_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PUSH_PER = 2,
  parameter int POP_PER  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  output logic              upFire,
  input  logic              upDone,
  output logic              downFire,
  input  logic              downDone,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  output logic [DATA_W-1:0] popData
);
  localparam int ITEMS    = PUSH_PER * POP_PER / gcdOf(PUSH_PER, POP_PER);
  localparam int UP_FIRES = ITEMS / PUSH_PER;
  localparam int DN_FIRES = ITEMS / POP_PER;
  localparam int PTR_W    = $clog2(ITEMS + 1);

  buf_stb_t         stb;
  logic [PTR_W-1:0] dpWrPtr;
  logic [PTR_W-1:0] dpRdPtr;

  sched_ctrl_fsm #(.UP_FIRES(UP_FIRES), .DN_FIRES(DN_FIRES)) ctl (
    .clk(clk), .rstN(rstN), .run(run), .upDone(upDone), .downDone(downDone),
    .upFire(upFire), .downFire(downFire), .stb(stb)
  );

  sched_pingpong_buf #(.DATA_W(DATA_W), .ITEMS(ITEMS), .PTR_W(PTR_W)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pushEn(pushEn), .pushData(pushData),
    .popEn(popEn), .popData(popData), .wrPtr(dpWrPtr), .rdPtr(dpRdPtr)
  );

endmodule

// File: rtl/static_sched_chk.sv
module static_sched_chk #(
  parameter int ITEMS = 6,
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             upFire,
  input logic             upDone,
  input logic             downFire,
  input logic             downDone,
  input logic             pushEn,
  input logic             swapHalves,
  input logic             primed,
  input logic [PTR_W-1:0] wrPtr,
  input logic [PTR_W-1:0] rdPtr
);
  logic busy;

  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else if (upFire || downFire) busy <= 1'b1;
    else if (upDone || downDone) busy <= 1'b0;
  end

  AST_FIRE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(upFire && downFire)); // R2
  AST_UP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    upFire |=> !upFire); // R2
  AST_DN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    downFire |=> !downFire); // R2
  AST_WAIT_FOR_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (upFire || downFire) |-> !busy); // R3
  AST_WARMUP_NO_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    !primed |-> !downFire); // R4
  AST_SWAP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    swapHalves |-> (wrPtr == PTR_W'(ITEMS))); // R5
  AST_SWAP_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    (swapHalves && primed) |-> (rdPtr == PTR_W'(ITEMS))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pushEn |-> (wrPtr < PTR_W'(ITEMS))); // R6

endmodule

bind static_sched_ctrl static_sched_chk #(.ITEMS(ITEMS), .PTR_W(PTR_W)) chk (
  .clk(clk), .rstN(rstN), .upFire(upFire), .upDone(upDone),
  .downFire(downFire), .downDone(downDone), .pushEn(pushEn),
  .swapHalves(stb.swapHalves), .primed(stb.readArmed),
  .wrPtr(dpWrPtr), .rdPtr(dpRdPtr)
);

// File: tb/static_sched_ctrl_test.sv
module static_sched_ctrl_test;
  localparam int DATA_W = 16;
  localparam int ITEMS  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0;
  logic upFire, downFire;
  logic upDone = 1'b0, downDone = 1'b0;
  logic pushEn = 1'b0, popEn = 1'b0;
  logic [DATA_W-1:0] pushData = '0;
  logic [DATA_W-1:0] popData;

  int checks = 0, failures = 0;
  int upFires = 0, dnFires = 0;
  int wrCount = 0, rdCount = 0;
  int randLat = 1;
  int step = 0;
  int modelPrimed = 0;
  int busy = 0;
  int cycles = 0;
  int seedDummy;
  logic [DATA_W-1:0] base;

  // period order: 1 = up, 0 = down
  int order [5] = '{1, 0, 1, 0, 1};

  always #4 clk = ~clk;

  static_sched_ctrl #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .run(run), .upFire(upFire), .upDone(upDone),
    .downFire(downFire), .downDone(downDone), .pushEn(pushEn),
    .pushData(pushData), .popEn(popEn), .popData(popData)
  );

  function automatic logic [DATA_W-1:0] expItem(int n);
    return DATA_W'(n * 37) + base;
  endfunction

  function automatic int pickLat();
    return (randLat != 0) ? int'($urandom_range(0, 4)) : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // fire-order monitor
  always @(negedge clk) begin
    if (rstN && (upFire || downFire)) begin
      while (modelPrimed == 0 && order[step] == 0) step++;
      check(busy == 0, "R3 fire while a firing is outstanding", busy, 0);
      check(!(upFire && downFire), "R2 both fires high", 1, 0);
      if (modelPrimed == 0)
        check(upFire, "R4 warm-up period fires only upstream", int'(upFire), 1);
      else
        check(int'(upFire) == order[step], "R2 firing order", int'(upFire), order[step]);
      if (upFire) upFires++;
      if (downFire) dnFires++;
      busy = 1;
      step++;
      if (step == 5) begin
        step = 0;
        modelPrimed = 1;
      end
    end
  end

  // upstream filter
  always begin
    @(negedge clk);
    if (rstN && upFire) begin
      for (int k = 0; k < 2; k++) begin
        pushEn = 1'b1;
        pushData = expItem(wrCount);
        @(negedge clk);
        wrCount++;
      end
      pushEn = 1'b0;
      repeat (pickLat()) @(negedge clk);
      busy = 0;
      upDone = 1'b1;
      @(negedge clk);
      upDone = 1'b0;
    end
  end

  // downstream filter
  always begin
    @(negedge clk);
    if (rstN && downFire) begin
      for (int k = 0; k < 3; k++) begin
        check(popData == expItem(rdCount), "R6 R8 item order", int'(popData),
              int'(expItem(rdCount)));
        popEn = 1'b1;
        @(negedge clk);
        rdCount++;
      end
      popEn = 1'b0;
      repeat (pickLat()) @(negedge clk);
      busy = 0;
      downDone = 1'b1;
      @(negedge clk);
      downDone = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int snapUp;
    int snapDn;
    seedDummy = $urandom(32'h5eed);
    base = DATA_W'($urandom_range(0, 1000));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!upFire && !downFire, "R1 no fire while idle", int'(upFire | downFire), 0);
    end

    // directed: warm-up and first primed period, zero latency
    randLat = 0;
    run = 1'b1;
    while (upFires < 3) @(negedge clk);
    check(dnFires == 0, "R4 no downstream firing in warm-up", dnFires, 0);
    while (dnFires < 4) @(negedge clk);

    // random done latencies over many periods
    randLat = 1;
    while (dnFires < 80) @(negedge clk);

    // stop mid-period
    while (upFires % 3 != 1) @(negedge clk);
    run = 1'b0;
    repeat (80) @(negedge clk);
    snapUp = upFires;
    snapDn = dnFires;
    check(upFires % 3 == 0, "R7 period completes after stop", upFires % 3, 0);
    check(dnFires * 3 == (upFires - 3) * 2, "R5 down firings balance", dnFires,
          (upFires - 3) * 2 / 3);
    check(wrCount - rdCount == ITEMS, "R5 one half parked", wrCount - rdCount, ITEMS);
    check(rdCount == dnFires * 3, "R8 every pop taken", rdCount, dnFires * 3);
    repeat (60) @(negedge clk);
    check(upFires == snapUp && dnFires == snapDn, "R7 no fire while parked",
          upFires + dnFires, snapUp + snapDn);

    // resume: buffered items first, no second warm-up
    randLat = 0;
    run = 1'b1;
    while (dnFires < snapDn + 1) @(negedge clk);
    check(upFires == snapUp + 1, "R7 resume includes downstream slot", upFires, snapUp + 1);
    randLat = 1;
    while (dnFires < snapDn + 30) @(negedge clk);
    run = 1'b0;
    repeat (80) @(negedge clk);
    check(wrCount - rdCount == ITEMS, "R6 one period in flight", wrCount - rdCount, ITEMS);
    check(upFires % 3 == 0, "R7 second stop on boundary", upFires % 3, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule